// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block resolves every register access of an 8-bit core into a single target. An access names either a full 8-bit register address or a 4-bit working register number. A working register number is joined under the upper nibble of a pointer register to form the address. The lower nibble of the same pointer picks an alternate bank. When that bank is nonzero, it takes the place of the lowest sixteen addresses and hides the standard contents there.

The pointer sits at address FDH of the standard space. The block also holds the 256-byte standard storage. For the two implemented alternate banks, a serial-peripheral bank (C) and a system-control bank (F), the block raises a one-hot target select, a local offset and a write strobe. It also takes their read data, so peripheral registers kept outside can be attached. Locations that exist in no bank read as FFH, and writes to them do nothing.

Top module: `banked_rf_mapper`

## Requirements
- R1: After a synchronous active-low reset the pointer `ptr` is 00H, which selects bank 0 and working group 0.
- R2: With `use_work` high, the resolved address is {ptr[7:4], work_reg}, and `acc_addr` is ignored.
- R3: When ptr[3:0] is 0, every resolved address reaches standard storage. A nonzero ptr[3:0] remaps only resolved addresses 00H to 0FH to that bank, and ptr[3:0] = 0 brings the standard contents there back.
- R4: Resolved addresses 10H to FFH always reach standard storage, whatever the bank.
- R5: `sel` is one-hot while `rd_en` or `wr_en` is high: bit 0 standard, bit 1 bank C, bit 2 bank F, bit 3 reserved. It is 0000 when neither strobe is high.
- R6: In bank F only offsets 0H, BH and FH are implemented. In bank C only offsets 0H, 1H and 2H are implemented. Banks 1 to B, D and E are reserved entirely. For a bank target, `loc_off` is {4'h0, low nibble}. For a standard target it is the full resolved address.
- R7: A read of a reserved location returns FFH. A write to one changes no storage and no pointer, and raises no `per_we`.
- R8: A write whose resolved address is FDH loads `ptr` at that clock edge. The access in the write cycle itself is resolved with the old pointer. A read of FDH returns `ptr`.
- R9: `per_we` is high exactly for writes to implemented bank C or bank F locations. `rd_data` then returns `serial_rdata` or `sys_rdata` respectively.
- R10: Standard reads return the byte last written to that resolved address. The read is combinational, and the write takes effect on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Full register address |
| use_work | input | 1 | Resolve from work_reg instead of acc_addr |
| work_reg | input | 4 | Working register number |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the resolved target |
| sel | output | 4 | One-hot target select |
| loc_off | output | 8 | Local offset within the target |
| per_we | output | 1 | Write strobe to an implemented bank register |
| serial_rdata | input | 8 | Read data of the bank C register at loc_off |
| sys_rdata | input | 8 | Read data of the bank F register at loc_off |
| ptr | output | 8 | Current pointer value |

## Verification
Some properties are checked by the assertions on every cycle. These are the one-hot shape of the select and its silence when no strobe is high. They also cover the immunity of upper addresses and of bank 0 to remapping, the FFH answer of reserved reads, the strobe gating of `per_we`, and the pointer load after a write to FDH. Other behaviour shows only in the bench's sweeps. One sweep covers every bank nibble against every low offset. Another covers every working group and register against the stored pattern. Further scenarios show that standard bytes survive hidden writes to reserved and peripheral locations, and that the access in the same cycle as a pointer write is resolved with the old pointer.

// File: rtl/banked_rf_mapper_pkg.sv
// Shared target encoding and implemented-offset tests for the address mapper.
// Assumes 4-bit bank nibbles and 4-bit low-window offsets.
package banked_rf_mapper_pkg;

    // Index of each target; equals its bit position in the one-hot select.
    typedef enum logic [1:0] {
        TGT_STD    = 2'd0,
        TGT_SERIAL = 2'd1,
        TGT_SYS    = 2'd2,
        TGT_RSV    = 2'd3
    } tgt_e;

    localparam int TGT_COUNT = 4;

    // Offsets present in the serial-peripheral bank.
    function automatic logic serial_off_ok(input logic [3:0] off);
        return off <= 4'h2;
    endfunction

    // Offsets present in the system-control bank.
    function automatic logic sys_off_ok(input logic [3:0] off);
        return (off == 4'h0) || (off == 4'hB) || (off == 4'hF);
    endfunction

endpackage

// File: rtl/banked_rf_ptr.sv
// Pointer register: upper nibble is the working group, lower nibble the bank.
// Assumes the caller gates the write enable with the pointer address hit.
module banked_rf_ptr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // Hold the pointer; clear to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

endmodule

// File: rtl/banked_rf_resolve.sv
// Combinational address resolution: forms the working-register address,
// applies the low-window bank remap and classifies the target.
// Assumes ADDR_W = 2 * NIB_W so the group nibble fills the upper half.
module banked_rf_resolve
    import banked_rf_mapper_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [3:0]  BANK_SERIAL = 4'hC,
    parameter logic [3:0]  BANK_SYS    = 4'hF
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              use_work,
    input  logic [ADDR_W/2-1:0] work_reg,
    output logic [ADDR_W-1:0] eff,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] off
);

    localparam int NIB_W = ADDR_W / 2;

    logic [NIB_W-1:0] bank;
    logic             in_window;

    // Build the effective address from full or working form.
    always_comb begin
        eff = use_work ? {ptr[ADDR_W-1:NIB_W], work_reg} : acc_addr;
    end

    assign bank      = ptr[NIB_W-1:0];
    assign in_window = (eff[ADDR_W-1:NIB_W] == '0);

    // Classify the target and produce its local offset.
    always_comb begin
        tgt = TGT_STD;
        off = eff;
        if (in_window && bank != '0) begin
            off = {{NIB_W{1'b0}}, eff[NIB_W-1:0]};
            if (bank == BANK_SERIAL)
                tgt = serial_off_ok(eff[NIB_W-1:0]) ? TGT_SERIAL : TGT_RSV;
            else if (bank == BANK_SYS)
                tgt = sys_off_ok(eff[NIB_W-1:0]) ? TGT_SYS : TGT_RSV;
            else
                tgt = TGT_RSV;
        end
    end

endmodule

// File: rtl/banked_rf_store.sv
// Standard register storage: one write port, one combinational read port.
// Assumes contents are undefined until written; no reset on the array.
module banked_rf_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a write on the clock edge.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/banked_rf_mapper.sv
// Top: resolves each register access to standard storage, the pointer,
// the serial bank, the system bank or a reserved hole, and routes data.
// Assumes at most one access per cycle; peripheral registers live outside.
module banked_rf_mapper
    import banked_rf_mapper_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter logic [7:0] PTR_ADDR    = 8'hFD,
    parameter logic [3:0] BANK_SERIAL = 4'hC,
    parameter logic [3:0] BANK_SYS    = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              use_work,
    input  logic [ADDR_W/2-1:0] work_reg,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [TGT_COUNT-1:0] sel,
    output logic [ADDR_W-1:0] loc_off,
    output logic              per_we,
    input  logic [DATA_W-1:0] serial_rdata,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic [DATA_W-1:0] ptr
);

    logic [ADDR_W-1:0] eff;
    tgt_e              tgt;
    logic              access;
    logic              ptr_hit;
    logic              ptr_we;
    logic              store_we;
    logic [DATA_W-1:0] store_rdata;

    banked_rf_resolve #(
        .ADDR_W      (ADDR_W),
        .BANK_SERIAL (BANK_SERIAL),
        .BANK_SYS    (BANK_SYS)
    ) i_resolve (
        .ptr      (ptr),
        .acc_addr (acc_addr),
        .use_work (use_work),
        .work_reg (work_reg),
        .eff      (eff),
        .tgt      (tgt),
        .off      (loc_off)
    );

    assign access   = rd_en | wr_en;
    assign ptr_hit  = (tgt == TGT_STD) && (eff == ADDR_W'(PTR_ADDR));
    assign ptr_we   = wr_en && ptr_hit;
    assign store_we = wr_en && (tgt == TGT_STD) && !ptr_hit;
    assign per_we   = wr_en && ((tgt == TGT_SERIAL) || (tgt == TGT_SYS));

    banked_rf_ptr #(.DATA_W(DATA_W)) i_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ptr_we),
        .wdata (wr_data),
        .q     (ptr)
    );

    banked_rf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk   (clk),
        .we    (store_we),
        .addr  (eff),
        .wdata (wr_data),
        .rdata (store_rdata)
    );

    // One select line per target, raised only during an access.
    for (genvar g = 0; g < TGT_COUNT; g++) begin : g_sel
        assign sel[g] = access && (tgt == tgt_e'(g));
    end

    // Pick read data from the resolved target.
    always_comb begin
        unique case (tgt)
            TGT_STD:    rd_data = ptr_hit ? ptr : store_rdata;
            TGT_SERIAL: rd_data = serial_rdata;
            TGT_SYS:    rd_data = sys_rdata;
            default:    rd_data = '1;
        endcase
    end

endmodule

// File: rtl/banked_rf_mapper_chk.sv
// Cycle-by-cycle properties of the mapper, observed at its ports.
// Assumes the default 8-bit configuration with the pointer at FDH.
module banked_rf_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] acc_addr,
    input logic       use_work,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [3:0] sel,
    input logic       per_we,
    input logic [7:0] ptr
);

    // R5: at most one target selected, none without a strobe.
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && ((rd_en || wr_en) == (sel != 4'b0000)));

    // R4: upper full addresses always reach standard storage.
    a_r4_upper_std: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !use_work && acc_addr[7:4] != 4'h0) |-> sel == 4'b0001);

    // R3: bank 0 never remaps.
    a_r3_bank0_std: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && ptr[3:0] == 4'h0) |-> sel == 4'b0001);

    // R7: reserved reads answer all ones.
    a_r7_rsv_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel[3]) |-> rd_data == 8'hFF);

    // R9: peripheral strobe only on writes to implemented bank registers.
    a_r9_per_we_gate: assert property (@(posedge clk) disable iff (!rst_n)
        per_we |-> (wr_en && (sel[1] || sel[2])));

    // R8: full-address write to the pointer loads it at the edge.
    a_r8_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !use_work && acc_addr == 8'hFD) |=> ptr == $past(wr_data));

endmodule

bind banked_rf_mapper banked_rf_mapper_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_addr (acc_addr),
    .use_work (use_work),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sel      (sel),
    .per_we   (per_we),
    .ptr      (ptr)
);

// File: tb/test_banked_rf_mapper.sv
module test_banked_rf_mapper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0;
    logic       use_work = 1'b0;
    logic [3:0] work_reg = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] sel;
    logic [7:0] loc_off;
    logic       per_we;
    logic [7:0] serial_rdata = 8'hA5;
    logic [7:0] sys_rdata = 8'h5A;
    logic [7:0] ptr;

    int errors = 0;
    int checks = 0;
    logic [7:0] cur_ptr = '0;

    always #5 clk = ~clk;

    banked_rf_mapper i_banked_rf_mapper (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .use_work(use_work),
        .work_reg(work_reg), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sel(sel), .loc_off(loc_off), .per_we(per_we),
        .serial_rdata(serial_rdata), .sys_rdata(sys_rdata), .ptr(ptr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h3C;
    endfunction

    function automatic logic [3:0] exp_sel(input logic [7:0] p, input logic [7:0] e);
        if (e[7:4] != 4'h0 || p[3:0] == 4'h0) return 4'b0001;
        if (p[3:0] == 4'hC) return (e[3:0] <= 4'h2) ? 4'b0010 : 4'b1000;
        if (p[3:0] == 4'hF)
            return (e[3:0] == 4'h0 || e[3:0] == 4'hB || e[3:0] == 4'hF) ? 4'b0100 : 4'b1000;
        return 4'b1000;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] p, input logic [7:0] e);
        case (exp_sel(p, e))
            4'b0001: return (e == 8'hFD) ? p : pat(e);
            4'b0010: return 8'hA5;
            4'b0100: return 8'h5A;
            default: return 8'hFF;
        endcase
    endfunction

    // Drive one access after the falling edge; outputs settle before the rising edge.
    task automatic drive(input logic rd, input logic wr, input logic uw,
                         input logic [7:0] a, input logic [3:0] r, input logic [7:0] d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; use_work = uw; acc_addr = a; work_reg = r; wr_data = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; use_work = 1'b0;
        #1;
    endtask

    task automatic set_ptr(input logic [7:0] v);
        drive(1'b0, 1'b1, 1'b0, 8'hFD, 4'h0, v);
        cur_ptr = v;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ptr after reset", ptr, 8'h00);
        rst_n = 1'b1;
        idle();
        chk("R5 sel idle", sel, 4'b0000);
        chk("R1 ptr still zero", ptr, 8'h00);

        // R10: fill standard storage with a pattern, pointer excluded.
        for (int a = 0; a < 256; a++) begin
            if (a != 8'hFD) drive(1'b0, 1'b1, 1'b0, 8'(a), 4'h0, pat(8'(a)));
        end
        idle();
        for (int a = 0; a < 256; a++) begin
            drive(1'b1, 1'b0, 1'b0, 8'(a), 4'h0, 8'h00);
            chk("R10 std readback", rd_data, exp_data(8'h00, 8'(a)));
        end

        // R3 R4 R6 R7 R9: sweep every bank against the low window and some upper addresses.
        for (int b = 0; b < 16; b++) begin
            set_ptr(8'(b));
            idle();
            chk("R8 ptr loaded", ptr, 8'(b));
            for (int a = 0; a < 20; a++) begin
                logic [7:0] ea;
                ea = (a < 16) ? 8'(a) : ((a == 16) ? 8'h10 : ((a == 17) ? 8'h8F : ((a == 18) ? 8'hF0 : 8'hFD)));
                drive(1'b1, 1'b0, 1'b0, ea, 4'h0, 8'h00);
                chk("R3 R4 R6 sel", sel, exp_sel(cur_ptr, ea));
                chk("R7 R9 R10 rd_data", rd_data, exp_data(cur_ptr, ea));
                chk("R6 loc_off", loc_off, (exp_sel(cur_ptr, ea) == 4'b0001) ? ea : {4'h0, ea[3:0]});
            end
        end

        // R2: every working group and register.
        for (int g = 0; g < 16; g++) begin
            set_ptr({4'(g), 4'h0});
            for (int r = 0; r < 16; r++) begin
                drive(1'b1, 1'b0, 1'b1, 8'h55, 4'(r), 8'h00);
                chk("R2 work sel", sel, 4'b0001);
                chk("R2 work rd_data", rd_data, exp_data(cur_ptr, {4'(g), 4'(r)}));
            end
        end

        // R7: reserved write has no effect.
        set_ptr(8'h05);
        drive(1'b0, 1'b1, 1'b0, 8'h03, 4'h0, 8'h77);
        chk("R7 rsv sel", sel, 4'b1000);
        chk("R7 rsv no per_we", per_we, 1'b0);
        // R9: implemented bank writes strobe out and leave storage alone.
        set_ptr(8'h0C);
        drive(1'b0, 1'b1, 1'b0, 8'h01, 4'h0, 8'h99);
        chk("R9 serial per_we", per_we, 1'b1);
        chk("R9 serial sel", sel, 4'b0010);
        set_ptr(8'h0F);
        drive(1'b0, 1'b1, 1'b0, 8'h0B, 4'h0, 8'h66);
        chk("R9 sys per_we", per_we, 1'b1);
        chk("R6 sys loc_off", loc_off, 8'h0B);
        drive(1'b0, 1'b1, 1'b0, 8'h20, 4'h0, 8'h20 ^ 8'h3C);
        chk("R9 std no per_we", per_we, 1'b0);
        set_ptr(8'h00);
        drive(1'b1, 1'b0, 1'b0, 8'h03, 4'h0, 8'h00);
        chk("R7 std 03 intact", rd_data, pat(8'h03));
        drive(1'b1, 1'b0, 1'b0, 8'h01, 4'h0, 8'h00);
        chk("R3 R9 std 01 intact", rd_data, pat(8'h01));
        drive(1'b1, 1'b0, 1'b0, 8'h0B, 4'h0, 8'h00);
        chk("R3 R9 std 0B intact", rd_data, pat(8'h0B));

        // R8: pointer write through a working register uses the old pointer.
        set_ptr(8'hF0);
        drive(1'b0, 1'b1, 1'b1, 8'h00, 4'hD, 8'h2C);
        chk("R8 old ptr in write cycle", ptr, 8'hF0);
        chk("R8 write cycle loc_off", loc_off, 8'hFD);
        cur_ptr = 8'h2C;
        drive(1'b1, 1'b0, 1'b1, 8'h00, 4'h3, 8'h00);
        chk("R8 new ptr next access", ptr, 8'h2C);
        chk("R8 R2 new group", rd_data, pat(8'h23));
        drive(1'b1, 1'b0, 1'b0, 8'hFD, 4'h0, 8'h00);
        chk("R8 read FD", rd_data, 8'h2C);
        drive(1'b1, 1'b0, 1'b0, 8'h02, 4'h0, 8'h00);
        chk("R3 bank C from new ptr", sel, 4'b0010);
        idle();
        chk("R5 sel idle end", sel, 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule